// File: doc/BRIEF.md
# Physical Memory Attribute Checker

This block decides, for every access that reaches physical memory, whether that access is permitted. It decides from the physical address alone. It does not care whether the address came straight from the core or from a virtual-to-physical translation. The address space is split into a small set of regions, and each region is a pair of inclusive address bounds. Each region carries six attribute flags:

- readable
- writable
- executable
- subword access permitted
- atomic operations permitted
- cacheable

The verdict depends only on the address, the access kind and the access size. Privilege level and execution context play no part.

The leading regions are fixed when the chip is built. They are set by parameters, and the register port cannot change them. The remaining regions are programmed by software through a small register port, and software can read back the bounds and flags of every region. A refused access gets a precise access-fault cause that matches its kind. These codes are kept apart from the page-fault codes (12, 13, 15). A registered fault strobe, with its cause, follows a valid request by one clock. Error responses from slaves that arrive too late to trap precisely are folded into a sticky bus-error interrupt, which software acknowledges.

Top module: `pmc_checker`

## Requirements
- R1: An address matches a region when base <= address <= limit, with both bounds inclusive. When several regions match, the one with the lowest index supplies the attributes.
- R2: An address that matches no region is refused for every access kind, and chk_cacheable is 0.
- R3: The access kind is encoded on req_type as 0 fetch, 1 load, 2 store, 3 atomic. Permission rules by kind:
  - A fetch needs the executable flag.
  - A load needs the readable flag.
  - A store needs the writable flag.
  - An atomic needs the readable, writable and atomic flags together.
- R4: The access size is encoded on req_size as 0 byte, 1 half, 2 word, 3 double. A byte or half access is refused when the region's subword flag is clear.
- R5: chk_allow and chk_cause are combinational on the request inputs. When an access is refused, chk_cause is 1 for a fetch, 5 for a load, and 7 for both stores and atomics. When an access is allowed, chk_cause is 0.
- R6: One clock after a cycle with req_valid high and the access refused, flt_valid is 1 and flt_cause holds that cause. In every other case flt_valid is 0 one clock later.
- R7: Each region n has a set of register offsets:
  - 4n+0: base
  - 4n+1: limit
  - 4n+2: attributes in bits [5:0], laid out as bit 0 readable, bit 1 writable, bit 2 executable, bit 3 subword, bit 4 atomic, bit 5 cacheable
  - 4n+3: reads 0
  A write to a programmable region takes effect after the write clock edge. Every field reads back through cfg_rdata, which is combinational on cfg_addr.
- R8: Writes to the offsets of a hardwired region are ignored. Those offsets always read the parameter values, and the region's verdicts do not change.
- R9: After reset, every programmable region has base 0xFFFFFFFF and limit 0, so it matches nothing. Its attributes read 0x0B: readable, writable and subword set; executable, atomic and cacheable clear.
- R10: A bus_err pulse sets bus_err_irq from the next clock onward. The bit stays set until a write with bit 0 equal to 1 reaches the status offset 4*NUM_REGIONS, where bit 0 reads as the pending bit. Writing 0 there has no effect. A new error in the same cycle as a clear wins.
- R11: chk_cacheable equals the cacheable flag of the region selected under R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request qualifier for the registered fault strobe |
| req_addr | input | ADDR_W | Physical address being checked |
| req_type | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 atomic |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| chk_allow | output | 1 | Access permitted (combinational) |
| chk_cause | output | 5 | Access-fault cause, 0 when allowed (combinational) |
| chk_cacheable | output | 1 | Cacheable flag of the selected region |
| flt_valid | output | 1 | Registered fault strobe |
| flt_cause | output | 5 | Cause belonging to flt_valid |
| bus_err | input | 1 | Late error response from a slave |
| bus_err_irq | output | 1 | Sticky imprecise bus-error interrupt |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register offset for both read and write |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data (combinational) |

## Verification
The verdict, the cause and the cacheable flag have no register on their path. The bench therefore drives a request half a clock away from the active edge and samples these outputs one time step later, with no clock edge in between.

The following are each due after exactly one rising edge, so the bench reads them at the falling edge that follows the edge which latched them:
- the fault strobe and its cause
- a register write
- an interrupt set or clear

Read data is combinational on the offset, so it is sampled the same way as the verdict.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_STORE  = 2'd2,
    ACC_ATOMIC = 2'd3
  } acc_e;

  // bit 0 readable ... bit 5 cacheable
  typedef struct packed {
    logic cache;
    logic amo;
    logic sub;
    logic x;
    logic w;
    logic r;
  } attr_t;

  localparam int ATTR_W = 6;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE     = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_AF = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_AF  = 5'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_AF = 5'd7;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam logic [ATTR_W-1:0] CFG_ATTR_RESET = 6'b001011;

endpackage

// File: rtl/pmc_region_file.sv
module pmc_region_file
  import pmc_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_FIXED   = 2,
  parameter int ADDR_W      = 32,
  parameter int CFG_AW      = 5,
  parameter logic [NUM_FIXED-1:0][ADDR_W-1:0] FIXED_BASE  = '0,
  parameter logic [NUM_FIXED-1:0][ADDR_W-1:0] FIXED_LIMIT = '0,
  parameter logic [NUM_FIXED-1:0][ATTR_W-1:0] FIXED_ATTR  = '0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [CFG_AW-1:0]                      wr_addr,
  input  logic [ADDR_W-1:0]                      wr_data,
  input  logic [CFG_AW-1:0]                      rd_addr,
  output logic [ADDR_W-1:0]                      rd_data,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     base_o,
  output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     limit_o,
  output logic [NUM_REGIONS-1:0][ATTR_W-1:0]     attr_o
);

  localparam int IDX_W = CFG_AW - 2;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    if (r < NUM_FIXED) begin : g_fixed
      assign base_o[r]  = FIXED_BASE[r];
      assign limit_o[r] = FIXED_LIMIT[r];
      assign attr_o[r]  = FIXED_ATTR[r];
    end else begin : g_prog
      localparam logic [CFG_AW-1:0] OFS_BASE  = CFG_AW'(4 * r);
      localparam logic [CFG_AW-1:0] OFS_LIMIT = CFG_AW'(4 * r + 1);
      localparam logic [CFG_AW-1:0] OFS_ATTR  = CFG_AW'(4 * r + 2);

      logic              base_en, limit_en, attr_en;
      logic [ADDR_W-1:0] base_q, limit_q;
      logic [ATTR_W-1:0] attr_q;

      always_comb begin
        base_en  = wr_en && (wr_addr == OFS_BASE);
        limit_en = wr_en && (wr_addr == OFS_LIMIT);
        attr_en  = wr_en && (wr_addr == OFS_ATTR);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q  <= '1;
          limit_q <= '0;
          attr_q  <= CFG_ATTR_RESET;
        end else begin
          if (base_en)  base_q  <= wr_data;
          if (limit_en) limit_q <= wr_data;
          if (attr_en)  attr_q  <= wr_data[ATTR_W-1:0];
        end
      end

      assign base_o[r]  = base_q;
      assign limit_o[r] = limit_q;
      assign attr_o[r]  = attr_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (rd_addr[CFG_AW-1:2] == IDX_W'(r)) begin
        case (rd_addr[1:0])
          2'd0:    rd_data = base_o[r];
          2'd1:    rd_data = limit_o[r];
          2'd2:    rd_data = ADDR_W'(attr_o[r]);
          default: rd_data = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/pmc_match.sv
module pmc_match
  import pmc_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32
) (
  input  logic [ADDR_W-1:0]                  addr_i,
  input  acc_e                               acc_i,
  input  logic [1:0]                         size_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] limit_i,
  input  logic [NUM_REGIONS-1:0][ATTR_W-1:0] attr_i,
  output logic                               hit_o,
  output logic                               allow_o,
  output logic [CAUSE_W-1:0]                 cause_o,
  output logic                               cache_o
);

  logic [NUM_REGIONS-1:0] in_range;
  attr_t                  sel;
  logic                   perm_ok;
  logic                   size_ok;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    assign in_range[r] = (addr_i >= base_i[r]) && (addr_i <= limit_i[r]);
  end

  // Descending scan: the lowest matching index is written last and wins.
  always_comb begin
    sel = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (in_range[r]) sel = attr_t'(attr_i[r]);
    end
  end

  assign hit_o = |in_range;

  always_comb begin
    unique case (acc_i)
      ACC_FETCH:  perm_ok = sel.x;
      ACC_LOAD:   perm_ok = sel.r;
      ACC_STORE:  perm_ok = sel.w;
      ACC_ATOMIC: perm_ok = sel.r & sel.w & sel.amo;
      default:    perm_ok = 1'b0;
    endcase
    size_ok = sel.sub || (size_i >= SIZE_WORD);
    allow_o = hit_o && perm_ok && size_ok;
    cache_o = hit_o && sel.cache;
  end

  always_comb begin
    if (allow_o) begin
      cause_o = CAUSE_NONE;
    end else begin
      unique case (acc_i)
        ACC_FETCH: cause_o = CAUSE_FETCH_AF;
        ACC_LOAD:  cause_o = CAUSE_LOAD_AF;
        default:   cause_o = CAUSE_STORE_AF;
      endcase
    end
  end

endmodule

// File: rtl/pmc_fault_reg.sv
module pmc_fault_reg
  import pmc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               allow,
  input  logic [CAUSE_W-1:0] cause,
  output logic               flt_valid,
  output logic [CAUSE_W-1:0] flt_cause
);

  logic               valid_d;
  logic               cause_en;
  logic [CAUSE_W-1:0] cause_q;

  always_comb begin
    valid_d  = req_valid && !allow;
    cause_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      cause_q   <= '0;
    end else begin
      flt_valid <= valid_d;
      if (cause_en) cause_q <= cause;
    end
  end

  assign flt_cause = cause_q;

endmodule

// File: rtl/pmc_irq.sv
module pmc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_d;
  logic pend_en;
  logic pend_q;

  always_comb begin
    pend_en = set_i | clr_i;
    pend_d  = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_FIXED   = 2,
  parameter int ADDR_W      = 32,
  parameter logic [NUM_FIXED-1:0][ADDR_W-1:0] FIXED_BASE  = {32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_FIXED-1:0][ADDR_W-1:0] FIXED_LIMIT = {32'h1000_0FFF, 32'h0000_FFFF},
  parameter logic [NUM_FIXED-1:0][ATTR_W-1:0] FIXED_ATTR  = {6'b000011, 6'b101101},
  localparam int CFG_AW = $clog2(NUM_REGIONS * 4 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_type,
  input  logic [1:0]         req_size,
  output logic               chk_allow,
  output logic [CAUSE_W-1:0] chk_cause,
  output logic               chk_cacheable,
  output logic               flt_valid,
  output logic [CAUSE_W-1:0] flt_cause,
  input  logic               bus_err,
  output logic               bus_err_irq,
  input  logic               cfg_wr_en,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0]  cfg_rdata
);

  localparam logic [CFG_AW-1:0] STATUS_OFS = CFG_AW'(NUM_REGIONS * 4);

  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] limit;
  logic [NUM_REGIONS-1:0][ATTR_W-1:0] attr;
  logic [ADDR_W-1:0]                  region_rdata;
  logic                               region_hit;
  logic                               irq_clr;

  pmc_region_file #(
    .NUM_REGIONS (NUM_REGIONS),
    .NUM_FIXED   (NUM_FIXED),
    .ADDR_W      (ADDR_W),
    .CFG_AW      (CFG_AW),
    .FIXED_BASE  (FIXED_BASE),
    .FIXED_LIMIT (FIXED_LIMIT),
    .FIXED_ATTR  (FIXED_ATTR)
  ) u_regions (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_addr (cfg_addr),
    .rd_data (region_rdata),
    .base_o  (base),
    .limit_o (limit),
    .attr_o  (attr)
  );

  pmc_match #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
  ) u_match (
    .addr_i  (req_addr),
    .acc_i   (acc_e'(req_type)),
    .size_i  (req_size),
    .base_i  (base),
    .limit_i (limit),
    .attr_i  (attr),
    .hit_o   (region_hit),
    .allow_o (chk_allow),
    .cause_o (chk_cause),
    .cache_o (chk_cacheable)
  );

  pmc_fault_reg u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .allow     (chk_allow),
    .cause     (chk_cause),
    .flt_valid (flt_valid),
    .flt_cause (flt_cause)
  );

  assign irq_clr = cfg_wr_en && (cfg_addr == STATUS_OFS) && cfg_wdata[0];

  pmc_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (bus_err),
    .clr_i  (irq_clr),
    .pend_o (bus_err_irq)
  );

  always_comb begin
    if (cfg_addr == STATUS_OFS) cfg_rdata = ADDR_W'(bus_err_irq);
    else                        cfg_rdata = region_rdata;
  end

endmodule

// File: rtl/pmc_checker_sva.sv
module pmc_checker_sva #(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int CFG_AW      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_type,
  input logic              region_hit,
  input logic              chk_allow,
  input logic [4:0]        chk_cause,
  input logic              chk_cacheable,
  input logic              flt_valid,
  input logic [4:0]        flt_cause,
  input logic              bus_err,
  input logic              bus_err_irq,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [ADDR_W-1:0] cfg_wdata
);

  logic status_clear;
  assign status_clear = cfg_wr_en && (cfg_addr == CFG_AW'(NUM_REGIONS * 4)) && cfg_wdata[0];

  a_r2_nomatch_denied: assert property (@(posedge clk) disable iff (!rst_n)
    !region_hit |-> !chk_allow);

  a_r5_cause_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_allow |-> (chk_cause == 5'd1 || chk_cause == 5'd5 || chk_cause == 5'd7));

  a_r5_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_allow && req_type == 2'd0) |-> chk_cause == 5'd1);

  a_r5_allowed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    chk_allow |-> chk_cause == 5'd0);

  a_r6_fault_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !chk_allow) |=> (flt_valid && flt_cause == $past(chk_cause)));

  a_r6_no_spurious_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !chk_allow) |=> !flt_valid);

  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err_irq);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err_irq && !status_clear) |=> bus_err_irq);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clear && !bus_err) |=> !bus_err_irq);

  a_r11_cache_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    chk_cacheable |-> region_hit);

endmodule

bind pmc_checker pmc_checker_sva #(
  .NUM_REGIONS (NUM_REGIONS),
  .ADDR_W      (ADDR_W),
  .CFG_AW      (CFG_AW)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_type      (req_type),
  .region_hit    (region_hit),
  .chk_allow     (chk_allow),
  .chk_cause     (chk_cause),
  .chk_cacheable (chk_cacheable),
  .flt_valid     (flt_valid),
  .flt_cause     (flt_cause),
  .bus_err       (bus_err),
  .bus_err_irq   (bus_err_irq),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_addr      (cfg_addr),
  .cfg_wdata     (cfg_wdata)
);

// File: tb/pmc_checker_test.sv
`timescale 1ns/1ps
module pmc_checker_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_type;
  logic [1:0]  req_size;
  logic        chk_allow;
  logic [4:0]  chk_cause;
  logic        chk_cacheable;
  logic        flt_valid;
  logic [4:0]  flt_cause;
  logic        bus_err;
  logic        bus_err_irq;
  logic        cfg_wr_en;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  int checks   = 0;
  int failures = 0;

  localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2, A = 2'd3;
  localparam logic [1:0] BYTE = 2'd0, HALF = 2'd1, WORD = 2'd2;

  pmc_checker uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_type      (req_type),
    .req_size      (req_size),
    .chk_allow     (chk_allow),
    .chk_cause     (chk_cause),
    .chk_cacheable (chk_cacheable),
    .flt_valid     (flt_valid),
    .flt_cause     (flt_cause),
    .bus_err       (bus_err),
    .bus_err_irq   (bus_err_irq),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic [1:0] t, input logic [1:0] s);
    @(negedge clk);
    req_addr = a; req_type = t; req_size = s;
    #1;
  endtask

  task automatic expect_verdict(input string tag, input logic [31:0] a, input logic [1:0] t,
                                input logic [1:0] s, input logic allow, input logic [4:0] cause);
    probe(a, t, s);
    check_eq({tag, " allow"}, 32'(chk_allow), 32'(allow));
    check_eq({tag, " cause"}, 32'(chk_cause), 32'(cause));
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check_eq(tag, cfg_rdata, exp);
  endtask

  task automatic t_reset;
    reg_read("R9 base reset", 5'd8, 32'hFFFF_FFFF);
    reg_read("R9 limit reset", 5'd9, 32'h0);
    reg_read("R9 attr reset", 5'd10, 32'h0B);
    reg_read("R10 status reset", 5'd16, 32'h0);
    check_eq("R6 flt_valid reset", 32'(flt_valid), 32'h0);
    expect_verdict("R9 empty region", 32'h2000_0000, L, WORD, 1'b0, 5'd5);
  endtask

  task automatic t_fixed;
    reg_read("R8 fixed attr read", 5'd2, 32'h2D);
    expect_verdict("R3 fixed fetch", 32'h0000_0100, F, WORD, 1'b1, 5'd0);
    check_eq("R11 fixed cacheable", 32'(chk_cacheable), 32'h1);
    expect_verdict("R4 fixed byte load", 32'h0000_FFFF, L, BYTE, 1'b1, 5'd0);
    expect_verdict("R3 fixed store", 32'h0000_0100, S, WORD, 1'b0, 5'd7);
    expect_verdict("R2 gap", 32'h0001_0000, L, WORD, 1'b0, 5'd5);
    check_eq("R2 gap cacheable", 32'(chk_cacheable), 32'h0);
    expect_verdict("R3 periph load", 32'h1000_0004, L, WORD, 1'b1, 5'd0);
    check_eq("R11 periph uncached", 32'(chk_cacheable), 32'h0);
    expect_verdict("R4 periph byte", 32'h1000_0004, L, BYTE, 1'b0, 5'd5);
    expect_verdict("R4 periph half store", 32'h1000_0004, S, HALF, 1'b0, 5'd7);
    expect_verdict("R3 periph fetch", 32'h1000_0004, F, WORD, 1'b0, 5'd1);
    reg_write(5'd2, 32'h0);
    reg_write(5'd0, 32'h8000_0000);
    reg_read("R8 fixed attr kept", 5'd2, 32'h2D);
    reg_read("R8 fixed base kept", 5'd0, 32'h0);
    expect_verdict("R8 fixed fetch kept", 32'h0000_0100, F, WORD, 1'b1, 5'd0);
  endtask

  task automatic t_program;
    reg_write(5'd8, 32'h2000_0000);
    reg_write(5'd9, 32'h2000_FFFF);
    reg_write(5'd10, 32'h33);
    reg_write(5'd12, 32'h2000_8000);
    reg_write(5'd13, 32'h2FFF_FFFF);
    reg_write(5'd14, 32'h05);
    reg_read("R7 attr readback", 5'd10, 32'h33);
    reg_read("R7 limit readback", 5'd9, 32'h2000_FFFF);
    reg_read("R7 base readback", 5'd12, 32'h2000_8000);
    reg_read("R7 pad reads zero", 5'd11, 32'h0);
    expect_verdict("R1 overlap store", 32'h2000_9000, S, WORD, 1'b1, 5'd0);
    check_eq("R11 overlap cacheable", 32'(chk_cacheable), 32'h1);
    expect_verdict("R1 overlap fetch", 32'h2000_9000, F, WORD, 1'b0, 5'd1);
    expect_verdict("R1 upper store", 32'h2001_0000, S, WORD, 1'b0, 5'd7);
    check_eq("R11 upper uncached", 32'(chk_cacheable), 32'h0);
    expect_verdict("R3 upper fetch", 32'h2001_0000, F, WORD, 1'b1, 5'd0);
    expect_verdict("R3 atomic ok", 32'h2000_0010, A, WORD, 1'b1, 5'd0);
    expect_verdict("R5 atomic denied", 32'h2001_0000, A, WORD, 1'b0, 5'd7);
    expect_verdict("R4 byte load", 32'h2000_0000, L, BYTE, 1'b0, 5'd5);
    expect_verdict("R1 limit incl", 32'h2FFF_FFFC, L, WORD, 1'b1, 5'd0);
    expect_verdict("R2 past limit", 32'h3000_0000, L, WORD, 1'b0, 5'd5);
    expect_verdict("R1 base incl", 32'h2000_0000, L, WORD, 1'b1, 5'd0);
  endtask

  task automatic t_fault_strobe;
    probe(32'h1000_0000, F, WORD);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R6 strobe valid", 32'(flt_valid), 32'h1);
    check_eq("R6 strobe cause", 32'(flt_cause), 32'd1);
    @(negedge clk);
    check_eq("R6 strobe one cycle", 32'(flt_valid), 32'h0);
    probe(32'h0000_0100, F, WORD);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R6 allowed no strobe", 32'(flt_valid), 32'h0);
    probe(32'h3000_0000, S, WORD);
    @(negedge clk);
    check_eq("R6 no valid no strobe", 32'(flt_valid), 32'h0);
    probe(32'h3000_0000, A, WORD);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R6 atomic strobe cause", 32'(flt_cause), 32'd7);
  endtask

  task automatic t_bus_err;
    @(negedge clk);
    bus_err = 1'b1;
    @(negedge clk);
    bus_err = 1'b0;
    check_eq("R10 irq set", 32'(bus_err_irq), 32'h1);
    reg_read("R10 status bit", 5'd16, 32'h1);
    reg_write(5'd16, 32'h0);
    check_eq("R10 zero write ignored", 32'(bus_err_irq), 32'h1);
    reg_write(5'd16, 32'h1);
    check_eq("R10 cleared", 32'(bus_err_irq), 32'h0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 5'd16; cfg_wdata = 32'h1; bus_err = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0; bus_err = 1'b0;
    check_eq("R10 set beats clear", 32'(bus_err_irq), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_type = '0; req_size = '0;
    bus_err = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fixed();
    t_program();
    t_fault_strobe();
    t_bus_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule